// File: doc/BRIEF.md
# SPI transfer buffer and DMA request controller

This block holds the words travelling between a register interface and an SPI shift engine. Bus writes land in a transmit buffer and the engine pulls them out one at a time. Each word the engine completes is stored in a receive buffer, and the bus drains that buffer. A two-bit mode input picks how deep each direction is and whether it applies flow control. The block stops the engine from starting a word when a flow-controlled receive buffer has no room. It also raises one DMA request per direction, and a priority input picks how each request reacts to its acknowledge.

The transfer sequencer has three named states:
- `ST_IDLE`: no word is in flight.
- `ST_XFER`: a word has been handed to the engine.
- `ST_HALT`: transfers are suspended because the receive buffer is full.

Its transitions are:
- IDLE→XFER when the engine takes a word.
- XFER→IDLE when the engine reports the word done.
- IDLE→HALT when a flow-controlled receive buffer is full.
- HALT→IDLE once that buffer has room again.

Top module: `spi_fifo_ctrl`

## Requirements
- R1: After reset both buffers are empty. `tx_full`, `rx_nempty`, `busy`, `eng_stall`, `eng_tx_valid` and `dma_rx_req` are 0, and `dma_tx_req` is 1.
- R2: With `cfg_mode`=0, the transmit buffer holds DEPTH words and `tx_full` rises when it has DEPTH words. A write while `tx_full` is 1 is discarded, and words reach the engine in write order.
- R3: With `cfg_mode`=0 the receive buffer holds DEPTH words in arrival order. Once it is full, `eng_stall` rises one cycle later, while `busy` and `eng_tx_valid` stay 0 even with transmit data waiting. A read releases the stall.
- R4: With `cfg_mode`=1, transmit is one word deep with no flow control. A new write replaces the stored word and `tx_full` stays 0. The receive buffer is DEPTH deep.
- R5: With `cfg_mode`=2, receive is one word deep with no flow control. A new word replaces the stored one and `eng_stall` never rises. The transmit buffer is DEPTH deep.
- R6: With `cfg_mode`=3 (the value software sees after reset), both directions are one word deep with flow control. One write sets `tx_full`, and one received word suspends transfers until it is read.
- R7: `busy` is 1 from the cycle after an accepted `eng_load` until the cycle after `eng_done`, and 0 otherwise.
- R8: With `cfg_prio`=0, each DMA request drops the cycle after its acknowledge. It returns after the next bus write (transmit) or bus read (receive), provided its level condition still holds.
- R9: With `cfg_prio`=1, acknowledges have no effect. `dma_tx_req` stays 1 until `tx_full` is 1, and `dma_rx_req` stays 1 until the receive buffer is empty.
- R10: `eng_tx_valid` is 1 only in IDLE, with transmit data present and the receive side not blocked. `eng_tx_word` is the oldest transmit word, and `eng_load` with `eng_tx_valid` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 2 | Buffer mode, 0..3 |
| cfg_prio | input | 1 | DMA request holding policy |
| tx_wr | input | 1 | Bus write strobe into transmit buffer |
| tx_wdata | input | W | Bus write data |
| rx_rd | input | 1 | Bus read strobe from receive buffer |
| rx_rdata | output | W | Oldest received word |
| tx_full | output | 1 | Transmit side cannot take a write |
| rx_nempty | output | 1 | Receive buffer holds data |
| busy | output | 1 | A word is in flight |
| eng_tx_valid | output | 1 | Engine may take a word |
| eng_tx_word | output | W | Word offered to the engine |
| eng_load | input | 1 | Engine takes the offered word |
| eng_done | input | 1 | Engine finished a word |
| eng_rx_word | input | W | Word received by the engine |
| eng_stall | output | 1 | Transfers suspended, receive full |
| dma_tx_ack | input | 1 | DMA acknowledge, transmit |
| dma_rx_ack | input | 1 | DMA acknowledge, receive |
| dma_tx_req | output | 1 | DMA request, transmit |
| dma_rx_req | output | 1 | DMA request, receive |

## Verification
The bench runs the transfer path in all four modes.

- Writing past capacity in the deep and single flow-controlled modes tells a dropped write from an overwrite.
- The two overwrite modes show the newest word replacing the stored one with no stall.
- Filling the receive side until it suspends, then reading, checks the HALT entry and exit.
- The DMA requests are driven with acknowledges under both priority settings, which shows the per-acknowledge release apart from level-held requests.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    typedef enum logic [1:0] {
        FM_DUPLEX  = 2'd0,
        FM_RX_ONLY = 2'd1,
        FM_TX_ONLY = 2'd2,
        FM_LEGACY  = 2'd3
    } fifo_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic deep;  // full parameter depth
        logic ovw;   // no flow control, newest word replaces stored one
    } dir_cfg_t;

    function automatic dir_cfg_t tx_cfg(input fifo_mode_e m);
        dir_cfg_t c;
        case (m)
            FM_DUPLEX:  c = '{deep: 1'b1, ovw: 1'b0};
            FM_RX_ONLY: c = '{deep: 1'b0, ovw: 1'b1};
            FM_TX_ONLY: c = '{deep: 1'b1, ovw: 1'b0};
            default:    c = '{deep: 1'b0, ovw: 1'b0};
        endcase
        return c;
    endfunction

    function automatic dir_cfg_t rx_cfg(input fifo_mode_e m);
        dir_cfg_t c;
        case (m)
            FM_DUPLEX:  c = '{deep: 1'b1, ovw: 1'b0};
            FM_RX_ONLY: c = '{deep: 1'b1, ovw: 1'b0};
            FM_TX_ONLY: c = '{deep: 1'b0, ovw: 1'b1};
            default:    c = '{deep: 1'b0, ovw: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         deep,
    input  logic         ovw,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         at_cap
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] CAP_DEEP = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt, lim;
    logic          pop_ok, app, rep;

    function automatic logic [AW-1:0] step_fwd(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + AW'(1);
    endfunction

    function automatic logic [AW-1:0] step_back(input logic [AW-1:0] p);
        return (p == '0) ? LAST_IDX : p - AW'(1);
    endfunction

    always_comb begin
        lim    = deep ? CAP_DEEP : CW'(1);
        at_cap = (cnt >= lim);
        empty  = (cnt == '0);
        pop_ok = pop && !empty;
        app    = push && (!at_cap || (ovw && pop_ok));
        rep    = push && at_cap && ovw && !pop_ok;
        dout   = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (app) begin
            mem[wr_ptr] <= din;
        end else if (rep) begin
            mem[step_back(wr_ptr)] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (app)    wr_ptr <= step_fwd(wr_ptr);
            if (pop_ok) rd_ptr <= step_fwd(rd_ptr);
            cnt <= cnt + CW'(app) - CW'(pop_ok);
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CAP_DEEP); // R2
    AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (at_cap && !ovw && !pop_ok) |=> (cnt == $past(cnt))); // R2
    AST_OVW_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (push && at_cap && ovw && !pop_ok && !deep) |=> (!empty && dout == $past(din))); // R4

endmodule

// File: rtl/spi_fifo_seq.sv
module spi_fifo_seq
    import spi_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_nempty,
    input  logic rx_block,
    input  logic load,
    input  logic done,
    output logic load_ok,
    output logic busy,
    output logic stall
);
    seq_state_e st, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: begin
                if (rx_block)                             st_nx = ST_HALT;
                else if (load && tx_nempty)               st_nx = ST_XFER;
            end
            ST_XFER: if (done)                            st_nx = ST_IDLE;
            ST_HALT: if (!rx_block)                       st_nx = ST_IDLE;
            default:                                      st_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load_ok = 1'b0;
        busy    = 1'b0;
        stall   = 1'b0;
        unique case (st)
            ST_IDLE: load_ok = tx_nempty && !rx_block;
            ST_XFER: busy    = 1'b1;
            ST_HALT: stall   = 1'b1;
            default: ;
        endcase
    end

    AST_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_ok) |=> busy); // R7
    AST_DONE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && done) |=> !busy); // R7

endmodule

// File: rtl/spi_fifo_dma.sv
module spi_fifo_dma (
    input  logic clk,
    input  logic rst_n,
    input  logic prio,
    input  logic level,
    input  logic ack,
    input  logic refill,
    output logic req
);
    logic gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             gap <= 1'b0;
        else if (ack && !prio)  gap <= 1'b1;
        else if (refill)        gap <= 1'b0;
    end

    assign req = level && (prio || !gap);

    AST_P0_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (!prio && ack) |=> (!req || prio)); // R8

endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
    import spi_fifo_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   cfg_mode,
    input  logic         cfg_prio,
    input  logic         tx_wr,
    input  logic [W-1:0] tx_wdata,
    input  logic         rx_rd,
    output logic [W-1:0] rx_rdata,
    output logic         tx_full,
    output logic         rx_nempty,
    output logic         busy,
    output logic         eng_tx_valid,
    output logic [W-1:0] eng_tx_word,
    input  logic         eng_load,
    input  logic         eng_done,
    input  logic [W-1:0] eng_rx_word,
    output logic         eng_stall,
    input  logic         dma_tx_ack,
    input  logic         dma_rx_ack,
    output logic         dma_tx_req,
    output logic         dma_rx_req
);
    localparam int NDIR = 2;

    dir_cfg_t tx_c, rx_c;
    logic tx_empty, tx_cap, rx_empty, rx_cap;
    logic rx_block, tx_pop, rx_push, load_ok, xfer_busy;
    logic [NDIR-1:0] lvl, ackv, rfl, reqv;

    always_comb begin
        tx_c = tx_cfg(fifo_mode_e'(cfg_mode));
        rx_c = rx_cfg(fifo_mode_e'(cfg_mode));
    end

    spi_fifo_buf #(.W(W), .DEPTH(DEPTH)) u_txbuf (
        .clk(clk), .rst_n(rst_n), .deep(tx_c.deep), .ovw(tx_c.ovw),
        .push(tx_wr), .din(tx_wdata), .pop(tx_pop),
        .dout(eng_tx_word), .empty(tx_empty), .at_cap(tx_cap)
    );

    spi_fifo_buf #(.W(W), .DEPTH(DEPTH)) u_rxbuf (
        .clk(clk), .rst_n(rst_n), .deep(rx_c.deep), .ovw(rx_c.ovw),
        .push(rx_push), .din(eng_rx_word), .pop(rx_rd),
        .dout(rx_rdata), .empty(rx_empty), .at_cap(rx_cap)
    );

    assign rx_block = rx_cap && !rx_c.ovw;

    spi_fifo_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tx_nempty(!tx_empty), .rx_block(rx_block),
        .load(eng_load), .done(eng_done),
        .load_ok(load_ok), .busy(xfer_busy), .stall(eng_stall)
    );

    assign eng_tx_valid = load_ok;
    assign tx_pop       = eng_load && load_ok;
    assign rx_push      = eng_done && xfer_busy;
    assign busy         = xfer_busy;
    assign tx_full      = tx_cap && !tx_c.ovw;
    assign rx_nempty    = !rx_empty;

    // index 0 = transmit, 1 = receive
    assign lvl  = {rx_nempty, !tx_full};
    assign ackv = {dma_rx_ack, dma_tx_ack};
    assign rfl  = {rx_rd, tx_wr};

    for (genvar d = 0; d < NDIR; d++) begin : g_dma
        spi_fifo_dma u_dma (
            .clk(clk), .rst_n(rst_n), .prio(cfg_prio),
            .level(lvl[d]), .ack(ackv[d]), .refill(rfl[d]), .req(reqv[d])
        );
    end

    assign dma_tx_req = reqv[0];
    assign dma_rx_req = reqv[1];

    AST_NO_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !rx_block); // R3
    AST_TXREQ_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !dma_tx_req); // R9
    AST_RXREQ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_nempty |-> !dma_rx_req); // R9
    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        eng_stall |-> (!busy && !eng_tx_valid)); // R3

endmodule

// File: tb/spi_fifo_ctrl_bench.sv
`timescale 1ns/1ps
module spi_fifo_ctrl_bench;
    localparam int W = 32;
    localparam int DEPTH = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, cfg_prio, tx_wr, rx_rd, eng_load, eng_done, dma_tx_ack, dma_rx_ack;
    logic [1:0] cfg_mode;
    logic [W-1:0] tx_wdata, eng_rx_word, rx_rdata, eng_tx_word;
    logic tx_full, rx_nempty, busy, eng_tx_valid, eng_stall, dma_tx_req, dma_rx_req;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [W-1:0] exp_tx[$];
    logic [W-1:0] exp_rx[$];

    spi_fifo_ctrl #(.W(W), .DEPTH(DEPTH)) u_spi_fifo_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_prio(cfg_prio),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
        .tx_full(tx_full), .rx_nempty(rx_nempty), .busy(busy),
        .eng_tx_valid(eng_tx_valid), .eng_tx_word(eng_tx_word),
        .eng_load(eng_load), .eng_done(eng_done), .eng_rx_word(eng_rx_word),
        .eng_stall(eng_stall), .dma_tx_ack(dma_tx_ack), .dma_rx_ack(dma_rx_ack),
        .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check1(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // model: depth and overwrite per direction from the mode code
    function automatic int tx_cap_m();
        return (cfg_mode == 2'd0 || cfg_mode == 2'd2) ? DEPTH : 1;
    endfunction
    function automatic int rx_cap_m();
        return (cfg_mode == 2'd0 || cfg_mode == 2'd1) ? DEPTH : 1;
    endfunction

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [W-1:0] d);
        @(posedge clk); #1;
        tx_wr = 1'b1; tx_wdata = d;
        if (exp_tx.size() < tx_cap_m()) exp_tx.push_back(d);
        else if (cfg_mode == 2'd1) begin void'(exp_tx.pop_back()); exp_tx.push_back(d); end
        @(posedge clk); #1;
        tx_wr = 1'b0;
    endtask

    task automatic rd();
        @(posedge clk); #1; rx_rd = 1'b1;
        @(posedge clk); #1; rx_rd = 1'b0;
    endtask

    task automatic load();
        @(posedge clk); #1; eng_load = 1'b1;
        @(posedge clk); #1; eng_load = 1'b0;
    endtask

    task automatic done(input logic [W-1:0] d);
        @(posedge clk); #1;
        eng_done = 1'b1; eng_rx_word = d;
        if (exp_rx.size() < rx_cap_m()) exp_rx.push_back(d);
        else if (cfg_mode == 2'd2) begin void'(exp_rx.pop_back()); exp_rx.push_back(d); end
        @(posedge clk); #1;
        eng_done = 1'b0;
    endtask

    task automatic ack_tx();
        @(posedge clk); #1; dma_tx_ack = 1'b1;
        @(posedge clk); #1; dma_tx_ack = 1'b0;
    endtask

    task automatic ack_rx();
        @(posedge clk); #1; dma_rx_ack = 1'b1;
        @(posedge clk); #1; dma_rx_ack = 1'b0;
    endtask

    // monitor: compares engine and bus outputs with the scoreboard queues
    always @(negedge clk) begin
        if (rst_n && eng_load) begin
            if (!eng_tx_valid || exp_tx.size() == 0) begin
                checks++; failures++;
                $display("FAIL R10 load refused actual_valid=%b expected=1 queued=%0d",
                         eng_tx_valid, exp_tx.size());
            end else begin
                check("R2 R10 tx word order", eng_tx_word, exp_tx.pop_front());
            end
        end
        if (rst_n && rx_rd) begin
            if (!rx_nempty || exp_rx.size() == 0) begin
                checks++; failures++;
                $display("FAIL R3 read on empty actual_nempty=%b expected=1 queued=%0d",
                         rx_nempty, exp_rx.size());
            end else begin
                check("R3 rx word order", rx_rdata, exp_rx.pop_front());
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cfg_mode = 2'd3; cfg_prio = 1'b1;
        tx_wr = 0; rx_rd = 0; eng_load = 0; eng_done = 0;
        dma_tx_ack = 0; dma_rx_ack = 0; tx_wdata = '0; eng_rx_word = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check1("R1 tx_full", tx_full, 1'b0);
        check1("R1 rx_nempty", rx_nempty, 1'b0);
        check1("R1 busy", busy, 1'b0);
        check1("R1 stall", eng_stall, 1'b0);
        check1("R1 tx_valid", eng_tx_valid, 1'b0);
        check1("R1 tx req", dma_tx_req, 1'b1);
        check1("R1 rx req", dma_rx_req, 1'b0);

        // R6: single-depth both ways with flow control
        wr(32'hA1);
        @(negedge clk);
        check1("R6 tx_full after one", tx_full, 1'b1);
        check1("R9 tx req low when full", dma_tx_req, 1'b0);
        wr(32'hA2);                         // dropped
        load();
        @(negedge clk);
        check1("R7 busy after load", busy, 1'b1);
        check1("R6 tx_full cleared", tx_full, 1'b0);
        done(32'h51);
        @(negedge clk);
        check1("R7 busy after done", busy, 1'b0);
        check1("R6 rx_nempty", rx_nempty, 1'b1);
        tick();
        @(negedge clk);
        check1("R6 stall with one rx", eng_stall, 1'b1);
        wr(32'hA3);
        @(negedge clk);
        check1("R3 no valid while halted", eng_tx_valid, 1'b0);
        check1("R3 not busy while halted", busy, 1'b0);
        rd();
        tick();
        @(negedge clk);
        check1("R6 stall released", eng_stall, 1'b0);
        check1("R10 valid after release", eng_tx_valid, 1'b1);
        load(); done(32'h52); rd(); tick(); tick();

        // R2 R3: mode 0, deep with flow control
        @(posedge clk); #1 cfg_mode = 2'd0;
        for (int i = 0; i < DEPTH + 1; i++) wr(32'hD0 + W'(i));
        @(negedge clk);
        check1("R2 tx_full at depth", tx_full, 1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            load(); done(32'hC0 + W'(i));
        end
        tick();
        @(negedge clk);
        check1("R3 stall when rx full", eng_stall, 1'b1);
        check1("R3 busy low when rx full", busy, 1'b0);
        wr(32'hE0);
        @(negedge clk);
        check1("R3 valid low with tx pending", eng_tx_valid, 1'b0);
        check1("R2 tx not full", tx_full, 1'b0);
        for (int i = 0; i < DEPTH; i++) rd();
        tick(); tick();
        load(); done(32'hC9); rd(); tick(); tick();

        // R4: mode 1, transmit overwrite
        @(posedge clk); #1 cfg_mode = 2'd1;
        wr(32'hF0);
        @(negedge clk);
        check1("R4 tx_full stays low", tx_full, 1'b0);
        wr(32'hF1);
        @(negedge clk);
        check1("R4 tx_full after overwrite", tx_full, 1'b0);
        load(); done(32'h60);
        wr(32'hF2); load(); done(32'h61);
        tick();
        @(negedge clk);
        check1("R4 rx deep no stall", eng_stall, 1'b0);
        check1("R4 rx holds data", rx_nempty, 1'b1);
        rd(); rd();
        @(negedge clk);
        check1("R4 rx drained", rx_nempty, 1'b0);

        // R5: mode 2, receive overwrite
        @(posedge clk); #1 cfg_mode = 2'd2;
        wr(32'h70); wr(32'h71);
        @(negedge clk);
        check1("R5 tx deep not full", tx_full, 1'b0);
        load(); done(32'h80);
        load(); done(32'h81);
        tick();
        @(negedge clk);
        check1("R5 no stall", eng_stall, 1'b0);
        check1("R5 busy low", busy, 1'b0);
        rd();
        @(negedge clk);
        check1("R5 single word read", rx_nempty, 1'b0);

        // R8: release on acknowledge
        @(posedge clk); #1 begin cfg_mode = 2'd0; cfg_prio = 1'b0; end
        ack_tx();
        @(negedge clk);
        check1("R8 tx req dropped", dma_tx_req, 1'b0);
        wr(32'h90);
        @(negedge clk);
        check1("R8 tx req back after write", dma_tx_req, 1'b1);
        load(); done(32'hB0);
        wr(32'h91); load(); done(32'hB1);
        @(negedge clk);
        check1("R8 rx req before ack", dma_rx_req, 1'b1);
        ack_rx();
        @(negedge clk);
        check1("R8 rx req dropped", dma_rx_req, 1'b0);
        rd();
        @(negedge clk);
        check1("R8 rx req back after read", dma_rx_req, 1'b1);
        rd();
        @(negedge clk);
        check1("R8 rx req low empty", dma_rx_req, 1'b0);

        // R9: held requests
        @(posedge clk); #1 cfg_prio = 1'b1;
        ack_tx();
        @(negedge clk);
        check1("R9 tx req ignores ack", dma_tx_req, 1'b1);
        wr(32'h92); load(); done(32'hB2);
        ack_rx();
        @(negedge clk);
        check1("R9 rx req ignores ack", dma_rx_req, 1'b1);
        rd();
        @(negedge clk);
        check1("R9 rx req low when empty", dma_rx_req, 1'b0);
        for (int i = 0; i < DEPTH; i++) wr(32'h93 + W'(i));
        @(negedge clk);
        check1("R9 tx req low when full", dma_tx_req, 1'b0);
        check1("R2 tx_full refilled", tx_full, 1'b1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule